// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Unit

This unit turns a program counter into one instruction per request for a core whose stream mixes 16-bit and 32-bit encodings. Word-aligned fetches go through a small direct-mapped buffer of recent words, indexed by word address. A miss reads the word through a combined translate-and-read port and then fills the buffer. A fetch that starts in the upper halfword of a word, with compressed mode on, goes around the buffer. The unit reads that halfword alone and looks at its two low bits. If they mark a 32-bit instruction, it issues a second, separately translated halfword read at the next address and joins the two halves.

The result leaves the unit as a one-cycle pulse. It is either an instruction on `out_valid` or a trap on `out_trap`, carrying a cause and the faulting virtual address. The sequencing is one state machine. Its states are **IDLE** (accepts a request and looks up the buffer), **WORD** (waits for a 32-bit read), **LO** (waits for the first halfword) and **HI** (waits for the second halfword).

Its transitions are:
- *accept-hit*: IDLE to IDLE.
- *accept-misaligned*: IDLE to IDLE.
- *accept-miss*: IDLE to WORD.
- *accept-straddle*: IDLE to LO.
- *word-done*: WORD to IDLE.
- *lo-short*: LO to IDLE.
- *lo-fault*: LO to IDLE.
- *lo-long*: LO to HI.
- *hi-done*: HI to IDLE.

Top module: `ifs_fetch`

## Requirements
- R1: An aligned fetch (`req_pc[1:0]`=0) whose word is held in the buffer with a matching tag returns that stored word on `out_valid` in the cycle after acceptance and issues no memory read.
- R2: An aligned fetch that misses issues exactly one 32-bit read (`mem_req_half`=0) at `req_pc`, returns the read data, and stores it so a repeat fetch of the same address hits.
- R3: The buffer slot is `req_pc[9:2]` (256 slots by default); a fetch of a different address mapping to the same slot misses and replaces the slot.
- R4: With `rvc_en`=1 and `req_pc[1:0]`=2, the unit issues one 16-bit read (`mem_req_half`=1, halfword in `mem_rsp_data[15:0]`) at `req_pc`; if bits [1:0] of that halfword are not 2'b11, the result is the halfword zero-extended and no second read is made.
- R5: If that halfword has bits [1:0]=2'b11, a second 16-bit read at `req_pc`+2 follows, and the result is {second halfword, first halfword}.
- R6: The halfword-offset path neither uses nor fills the buffer: it always reads memory, even when the containing word is buffered with stale data.
- R7: `req_pc[0]`=1, or `req_pc[1]`=1 with `rvc_en`=0, gives a trap with `out_cause`=0 (misaligned) and `out_bad_addr`=`req_pc` in the next cycle, with no memory read.
- R8: A read answered with `mem_rsp_fault`=1 ends the fetch with a trap, `out_cause`=1 (access fault) and `out_bad_addr` equal to that read's address; nothing is stored in the buffer.
- R9: A one-cycle `flush` pulse invalidates every buffer slot, so each later aligned fetch misses once.
- R10: Each accepted request yields exactly one pulse of `out_valid` or `out_trap`, never both. `req_ready` is high only when no memory read is outstanding. A memory request keeps its address until answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all buffer slots |
| req_valid | input | 1 | Fetch request |
| req_ready | output | 1 | Unit idle, request accepted |
| req_pc | input | ADDR_W | Fetch virtual address |
| rvc_en | input | 1 | Compressed mode enable |
| mem_req_valid | output | 1 | Translate-and-read request |
| mem_req_addr | output | ADDR_W | Virtual address of read |
| mem_req_half | output | 1 | 1 = 16-bit read, 0 = 32-bit read |
| mem_rsp_valid | input | 1 | Read answered |
| mem_rsp_data | input | 32 | Read data (halfword in bits 15:0) |
| mem_rsp_fault | input | 1 | Translation fault on this read |
| out_valid | output | 1 | Instruction result pulse |
| out_insn | output | 32 | Instruction word |
| out_trap | output | 1 | Trap result pulse |
| out_cause | output | 1 | 0 misaligned, 1 access fault |
| out_bad_addr | output | ADDR_W | Faulting virtual address |

## Verification
Random program counters are drawn from three kinds of pages. Ordinary pages mix hits, misses and slot aliasing. A page whose upper halfwords are forced long separates the two-read path from the one-read path and lets a straddle run into a faulting page. A forced-short page shows that the second read is skipped. The bench counts memory reads per fetch, and this tells a buffer hit from a miss. Memory contents change between fetches without a flush, so stale buffered words show that the halfword path bypasses the buffer. Flush pulses and odd or uncompressed-offset addresses cover invalidation and the misaligned trap.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WORD = 2'd1,
        ST_LO   = 2'd2,
        ST_HI   = 2'd3
    } ifs_state_e;

    localparam logic CAUSE_MISALIGN = 1'b0;
    localparam logic CAUSE_FAULT    = 1'b1;
endpackage

// File: rtl/ifs_len.sv
module ifs_len (
    input  logic [15:0] half,
    output logic        is_short
);
    // a halfword whose two low bits are not both set is a complete instruction
    assign is_short = (half[1:0] != 2'b11);
endmodule

// File: rtl/ifs_buffer.sv
module ifs_buffer #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output logic [31:0]       rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - 2 - IDX_W;

    logic [DEPTH-1:0] slot_ok;
    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic [31:0]      dat_mem [DEPTH];

    logic [IDX_W-1:0] rd_idx, wr_idx;
    assign rd_idx = rd_addr[IDX_W+1:2];
    assign wr_idx = wr_addr[IDX_W+1:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            slot_ok <= '0;
        else if (flush)
            slot_ok <= '0;
        else if (wr_en)
            slot_ok[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_addr[ADDR_W-1:IDX_W+2];
            dat_mem[wr_idx] <= wr_data;
        end
    end

    assign rd_hit  = (rd_addr[1:0] == 2'b00) && slot_ok[rd_idx] &&
                     (tag_mem[rd_idx] == rd_addr[ADDR_W-1:IDX_W+2]);
    assign rd_data = dat_mem[rd_idx];
endmodule

// File: rtl/ifs_fetch.sv
module ifs_fetch
    import ifs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_pc,
    input  logic              rvc_en,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_half,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    input  logic              mem_rsp_fault,
    output logic              out_valid,
    output logic [31:0]       out_insn,
    output logic              out_trap,
    output logic              out_cause,
    output logic [ADDR_W-1:0] out_bad_addr
);
    ifs_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pc_q;
    logic [15:0]       lo_q;

    logic        accept, misal, straddle;
    logic        buf_hit, fill_en, lo_short;
    logic [31:0] buf_data;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign misal     = req_pc[0] || (req_pc[1] && !rvc_en);
    assign straddle  = rvc_en && (req_pc[1:0] == 2'b10);

    assign mem_req_valid = (state_q != ST_IDLE);
    assign mem_req_half  = (state_q == ST_LO) || (state_q == ST_HI);
    assign mem_req_addr  = (state_q == ST_HI) ? pc_q + ADDR_W'(2) : pc_q;

    assign fill_en = (state_q == ST_WORD) && mem_rsp_valid && !mem_rsp_fault;

    ifs_buffer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .rd_addr (req_pc),
        .rd_hit  (buf_hit),
        .rd_data (buf_data),
        .wr_en   (fill_en),
        .wr_addr (pc_q),
        .wr_data (mem_rsp_data)
    );

    ifs_len u_len (
        .half     (mem_rsp_data[15:0]),
        .is_short (lo_short)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                if (misal)        state_d = ST_IDLE;  // accept-misaligned
                else if (straddle) state_d = ST_LO;   // accept-straddle
                else if (buf_hit)  state_d = ST_IDLE; // accept-hit
                else               state_d = ST_WORD; // accept-miss
            end
            ST_WORD: if (mem_rsp_valid) state_d = ST_IDLE;  // word-done
            ST_LO: if (mem_rsp_valid) begin
                if (mem_rsp_fault || lo_short) state_d = ST_IDLE; // lo-fault / lo-short
                else                           state_d = ST_HI;   // lo-long
            end
            ST_HI: if (mem_rsp_valid) state_d = ST_IDLE;    // hi-done
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q         <= '0;
            lo_q         <= '0;
            out_valid    <= 1'b0;
            out_trap     <= 1'b0;
            out_insn     <= '0;
            out_cause    <= CAUSE_MISALIGN;
            out_bad_addr <= '0;
        end else begin
            out_valid <= 1'b0;
            out_trap  <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    pc_q <= req_pc;
                    if (misal) begin
                        out_trap     <= 1'b1;
                        out_cause    <= CAUSE_MISALIGN;
                        out_bad_addr <= req_pc;
                    end else if (!straddle && buf_hit) begin
                        out_valid <= 1'b1;
                        out_insn  <= buf_data;
                    end
                end
                ST_WORD, ST_LO, ST_HI: if (mem_rsp_valid) begin
                    if (mem_rsp_fault) begin
                        out_trap     <= 1'b1;
                        out_cause    <= CAUSE_FAULT;
                        out_bad_addr <= mem_req_addr;
                    end else if (state_q == ST_WORD) begin
                        out_valid <= 1'b1;
                        out_insn  <= mem_rsp_data;
                    end else if (state_q == ST_LO) begin
                        lo_q <= mem_rsp_data[15:0];
                        if (lo_short) begin
                            out_valid <= 1'b1;
                            out_insn  <= {16'h0000, mem_rsp_data[15:0]};
                        end
                    end else begin
                        out_valid <= 1'b1;
                        out_insn  <= {mem_rsp_data[15:0], lo_q};
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ifs_fetch_chk.sv
module ifs_fetch_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_pc,
    input logic              rvc_en,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_req_half,
    input logic              mem_rsp_valid,
    input logic [31:0]       mem_rsp_data,
    input logic              mem_rsp_fault,
    input logic              out_valid,
    input logic [31:0]       out_insn,
    input logic              out_trap,
    input logic              out_cause,
    input logic [ADDR_W-1:0] out_bad_addr
);
    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, out_trap}));

    // R10
    idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7
    misalign_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_pc[0] || (req_pc[1] && !rvc_en)))
        |=> (out_trap && !out_cause && out_bad_addr == $past(req_pc)));

    // R8
    fault_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_rsp_valid && mem_rsp_fault)
        |=> (out_trap && out_cause && out_bad_addr == $past(mem_req_addr)));

    // R4
    short_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_half && mem_req_addr[1] && mem_rsp_valid &&
         !mem_rsp_fault && mem_rsp_data[1:0] != 2'b11)
        |=> (out_valid && out_insn == {16'h0000, $past(mem_rsp_data[15:0])}));

    // R2
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_half) |-> (mem_req_addr[1:0] == 2'b00));
endmodule

bind ifs_fetch ifs_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ifs_fetch_tb.sv
module ifs_fetch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_pc = '0;
    logic          rvc_en = 1'b0;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_half;
    logic          mem_rsp_valid = 1'b0;
    logic [31:0]   mem_rsp_data = '0;
    logic          mem_rsp_fault = 1'b0;
    logic          out_valid;
    logic [31:0]   out_insn;
    logic          out_trap;
    logic          out_cause;
    logic [AW-1:0] out_bad_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifs_fetch #(.ADDR_W(AW), .IDX_W(8)) u_dut (.*);

    int errors = 0;
    int checks = 0;
    int mem_reads = 0;
    int gen = 0;
    int wait_cnt = 0;

    logic        m_ok  [256];
    logic [31:0] m_tag [256];
    logic [31:0] m_dat [256];

    function automatic logic [31:0] word_at(input logic [31:0] a, input int g);
        logic [31:0] w;
        w = ({a[31:2], 2'b00} * 32'h9E3779B1) ^ (g * 32'h85EBCA6B) ^ 32'h1234_5678;
        if (a[15:8] == 8'hEF) w[17:16] = 2'b11;
        if (a[15:8] == 8'h0E) w[17:16] = 2'b00;
        return w;
    endfunction

    function automatic logic [15:0] half_at(input logic [31:0] a, input int g);
        logic [31:0] w;
        w = word_at(a, g);
        return a[1] ? w[31:16] : w[15:0];
    endfunction

    function automatic logic faulty(input logic [31:0] a);
        return a[15:12] == 4'hF;
    endfunction

    task automatic check(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory and translation responder
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid && rst_n) begin
                if (wait_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_fault = faulty(mem_req_addr);
                    mem_rsp_data  = mem_req_half ? {16'h0000, half_at(mem_req_addr, gen)}
                                                 : word_at(mem_req_addr, gen);
                    mem_reads++;
                    wait_cnt = int'($urandom % 3);
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        foreach (m_ok[i]) m_ok[i] = 1'b0;
    endtask

    task automatic fetch(input logic [31:0] pc, input logic rvc);
        logic        e_trap, e_cause;
        logic [31:0] e_insn, e_bad;
        int          e_reads, start, cyc;
        logic [15:0] lo;
        string       tag;
        int          idx;
        e_trap = 0; e_cause = 0; e_insn = 0; e_bad = 0; e_reads = 0;
        idx = int'(pc[9:2]);
        if (pc[0] || (pc[1] && !rvc)) begin
            tag = "R7"; e_trap = 1; e_cause = 0; e_bad = pc;
        end else if (pc[1]) begin
            lo = half_at(pc, gen);
            e_reads = 1;
            if (faulty(pc)) begin
                tag = "R8"; e_trap = 1; e_cause = 1; e_bad = pc;
            end else if (lo[1:0] != 2'b11) begin
                tag = "R4"; e_insn = {16'h0000, lo};
            end else begin
                e_reads = 2;
                if (faulty(pc + 2)) begin
                    tag = "R8"; e_trap = 1; e_cause = 1; e_bad = pc + 2;
                end else begin
                    tag = "R5"; e_insn = {half_at(pc + 2, gen), lo};
                end
            end
        end else if (m_ok[idx] && m_tag[idx] == pc) begin
            tag = "R1"; e_insn = m_dat[idx];
        end else begin
            e_reads = 1;
            if (faulty(pc)) begin
                tag = "R8"; e_trap = 1; e_cause = 1; e_bad = pc;
            end else begin
                tag = "R2"; e_insn = word_at(pc, gen);
                m_ok[idx] = 1'b1; m_tag[idx] = pc; m_dat[idx] = e_insn;
            end
        end

        start = mem_reads;
        cyc = 0;
        while (!req_ready && cyc < 50) begin @(negedge clk); cyc++; end
        req_valid = 1'b1; req_pc = pc; rvc_en = rvc;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!(out_valid || out_trap) && cyc < 100) begin @(negedge clk); cyc++; end
        if (cyc >= 100) begin
            check("R10 timeout", 1'b0, 64'(cyc), 64'd0);
        end else if (e_trap) begin
            check(tag, out_trap && !out_valid && out_cause == e_cause && out_bad_addr == e_bad,
                  {out_trap, out_cause, out_bad_addr}, {e_trap, e_cause, e_bad});
        end else begin
            check(tag, out_valid && !out_trap && out_insn == e_insn,
                  {out_valid, out_insn}, {1'b1, e_insn});
        end
        check({tag, " reads"}, (mem_reads - start) == e_reads,
              64'(mem_reads - start), 64'(e_reads));
        @(negedge clk);
        check("R10 single pulse", !out_valid && !out_trap, {out_valid, out_trap}, 64'd0);
    endtask

    initial begin
        int n = 0;
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=done", n);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        foreach (m_ok[i]) m_ok[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset", !out_valid && !out_trap && req_ready && !mem_req_valid,
              {out_valid, out_trap, req_ready, mem_req_valid}, 64'b0010);
        rst_n = 1'b1;
        @(negedge clk);

        fetch(32'h0000_0100, 1'b0);           // R2 miss
        fetch(32'h0000_0100, 1'b0);           // R1 hit
        gen++;
        fetch(32'h0000_0100, 1'b0);           // R1 stale hit, no read
        fetch(32'h0000_0102, 1'b1);           // R6 bypass reads new data
        fetch(32'h0000_0100, 1'b1);           // R6 still buffered after straddle
        do_flush();                           // R9
        fetch(32'h0000_0100, 1'b0);           // R9 miss after flush
        fetch(32'h0000_0500, 1'b0);           // R3 alias evicts
        fetch(32'h0000_0100, 1'b0);           // R3 original misses again
        fetch(32'h0000_0101, 1'b1);           // R7 odd
        fetch(32'h0000_0102, 1'b0);           // R7 offset 2 uncompressed
        fetch(32'h0000_F000, 1'b0);           // R8 word fault
        fetch(32'h0000_F000, 1'b0);           // R8 not filled
        fetch(32'h0000_EFFE, 1'b1);           // R8 second halfword faults
        fetch(32'h0000_FFFE, 1'b1);           // R8 first halfword faults
        fetch(32'h0000_EF02, 1'b1);           // R5 long straddle
        fetch(32'h0000_0E02, 1'b1);           // R4 short straddle

        for (int k = 0; k < 400; k++) begin
            logic [31:0] pc;
            int sel;
            sel = int'($urandom % 8);
            pc = {16'h0000, 4'h0, 12'($urandom)};
            if (sel == 0) pc[15:12] = 4'hF;
            if (sel == 1) pc[15:8] = 8'hEF;
            if (sel == 2) pc[15:8] = 8'h0E;
            if ($urandom % 16 != 0) pc[0] = 1'b0;
            if ($urandom % 3 == 0) pc[1] = 1'b0;
            if ($urandom % 16 == 0) gen++;
            if ($urandom % 32 == 0) do_flush();
            fetch(pc, ($urandom % 4) != 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule